// File: doc/BRIEF.md
# Address translation cache

This block turns 32-bit virtual addresses into 32-bit physical addresses. It holds two kinds of mapping. The first is a fully associative set of 4 KB page mappings that the block fills on its own when a lookup misses. The second is a small bank of 512 KB region mappings that software loads through a write port. A lookup searches both kinds at once, and a region match wins over a page match. The low 12 bits of the address pass through untranslated for a page hit, and the low 19 bits pass through for a region hit. Addresses carry no address-space tag.

The result of a lookup is registered, so it appears one cycle after the request. A lookup that matches no mapping raises a walk request that carries the virtual page number. The request stays up until the page-table walker answers. The answer either installs a new page mapping or reports a fault, and a fault installs nothing. While a walk is outstanding, only one request is open at a time. An invalidate-all input clears every page mapping in one cycle and leaves the region mappings as they are.

Top module: `xlat_cache`

## Requirements
- R1: After reset, `rsp_valid` and `walk_req` are 0. A lookup made before any fill or region write reports a miss.
- R2: A lookup is answered in the cycle after it is presented. On a page hit, `rsp_hit`=1, `rsp_block`=0 and `rsp_paddr` = {stored physical page number, `lk_vaddr[11:0]`}.
- R3: On a region hit, `rsp_hit`=1, `rsp_block`=1 and `rsp_paddr` = {region physical base, `lk_vaddr[18:0]`}. This holds even when a page mapping also matches. A region matches when `lk_vaddr[31:19]` equals its virtual base.
- R4: When several valid regions match, the one with the lowest index supplies the translation.
- R5: When a lookup misses both kinds of mapping and no walk is open, `walk_req` rises in the answer cycle with `walk_vpn` = `lk_vaddr[31:12]`. It then holds, with `walk_vpn` stable, until `walk_rsp_valid`. Further misses raise no new request. A response with `walk_rsp_fault`=1 installs nothing.
- R6: A fill goes into the lowest-index invalid page slot. When no slot is invalid, it goes into the slot named by a round-robin pointer. The pointer is 0 after reset, advances by one (wrapping) only on such evicting fills, and is not reset by invalidate-all.
- R7: A one-cycle `inv_all` pulse makes every page mapping miss from the next lookup onward. Region mappings still hit.
- R8: A region write with `blk_valid`=0 removes that region. Later lookups fall through to a lower-priority match or miss.
- R9: When `inv_all` and a walk response arrive in the same cycle, the walk closes and the fill is dropped.
- R10: A lookup in the same cycle as a walk response sees the contents from before the fill and opens no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Answer is a translation |
| rsp_block | output | 1 | Answer came from a region mapping |
| rsp_paddr | output | 32 | Physical address (0 on a miss) |
| walk_req | output | 1 | Walk request open |
| walk_vpn | output | 20 | Virtual page number being walked |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_fault | input | 1 | Walker found no mapping |
| walk_rsp_ppn | input | 20 | Physical page number from the walker |
| inv_all | input | 1 | Clear all page mappings |
| blk_we | input | 1 | Region write strobe |
| blk_idx | input | log2(BLOCK_ENTRIES) | Region slot to write |
| blk_valid | input | 1 | Valid bit for the written region |
| blk_vbase | input | 13 | Region virtual base (address bits 31:19) |
| blk_pbase | input | 13 | Region physical base (address bits 31:19) |

## Verification
The hardest state to reach from the ports is the replacement order. Which slot a fill takes can only be seen indirectly, by checking which old mapping starts to miss. To reach it, the bench runs a small four-slot configuration. It fills every slot, forces evictions, and probes each known page for hit or miss, after invalidate-all as well. Each probe that misses is closed with a fault response, so the probe itself changes nothing. The same-cycle collisions (a fill with a lookup, a fill with invalidate-all) are driven in the same clock cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W    = 32;
    localparam int PA_W    = 32;
    localparam int PG_OFF  = 12;
    localparam int BLK_OFF = 19;
    localparam int VPN_W   = VA_W - PG_OFF;
    localparam int PPN_W   = PA_W - PG_OFF;
    localparam int BVN_W   = VA_W - BLK_OFF;
    localparam int BPN_W   = PA_W - BLK_OFF;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;
    typedef logic [BVN_W-1:0] bvn_t;
    typedef logic [BPN_W-1:0] bpn_t;

    typedef struct packed {
        logic valid;
        vpn_t vpn;
        ppn_t ppn;
    } page_ent_t;

    typedef struct packed {
        logic valid;
        bvn_t vbase;
        bpn_t pbase;
    } blk_ent_t;

    function automatic logic [PA_W-1:0] page_pa(ppn_t p, logic [VA_W-1:0] va);
        return {p, va[PG_OFF-1:0]};
    endfunction

    function automatic logic [PA_W-1:0] block_pa(bpn_t p, logic [VA_W-1:0] va);
        return {p, va[BLK_OFF-1:0]};
    endfunction
endpackage

// File: rtl/xlat_page_array.sv
module xlat_page_array
    import xlat_pkg::*;
#(
    parameter int N = 56,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic clk,
    input  logic rst,
    input  vpn_t lk_vpn,
    output logic hit,
    output ppn_t hit_ppn,
    input  logic inv_all,
    input  logic fill_en,
    input  vpn_t fill_vpn,
    input  ppn_t fill_ppn
);
    page_ent_t       ent [N];
    logic [N-1:0]    match;
    logic [IW-1:0]   rr_ptr;
    logic [IW-1:0]   free_idx;
    logic            any_free;
    logic [IW-1:0]   victim;

    always_comb begin
        hit_ppn = '0;
        for (int i = 0; i < N; i++) begin
            match[i] = ent[i].valid && (ent[i].vpn == lk_vpn);
            if (match[i]) hit_ppn = hit_ppn | ent[i].ppn;
        end
        hit = |match;
    end

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!ent[i].valid) begin
                any_free = 1'b1;
                free_idx = IW'(i);
            end
        end
        victim = any_free ? free_idx : rr_ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ent[i] <= '0;
            rr_ptr <= '0;
        end else if (inv_all) begin
            for (int i = 0; i < N; i++) ent[i].valid <= 1'b0;
        end else if (fill_en) begin
            ent[victim] <= '{valid: 1'b1, vpn: fill_vpn, ppn: fill_ppn};
            if (!any_free)
                rr_ptr <= (rr_ptr == IW'(N - 1)) ? '0 : rr_ptr + IW'(1);
        end
    end

    // R2: a virtual page is never held twice
    a_r2_single_match: assert property (@(posedge clk) disable iff (rst) $onehot0(match));
    // R6: pointer stays inside the array
    a_r6_ptr_range: assert property (@(posedge clk) disable iff (rst) rr_ptr <= IW'(N - 1));
    // R7: nothing hits after invalidate-all
    a_r7_inv_empties: assert property (@(posedge clk) disable iff (rst) inv_all |=> !hit);
endmodule

// File: rtl/xlat_block_array.sv
module xlat_block_array
    import xlat_pkg::*;
#(
    parameter int M = 10,
    localparam int BW = (M > 1) ? $clog2(M) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [BW-1:0] widx,
    input  logic          wvalid,
    input  bvn_t          wvbase,
    input  bpn_t          wpbase,
    input  bvn_t          lk_bvn,
    output logic          hit,
    output bpn_t          hit_pbase
);
    blk_ent_t     ent [M];
    logic [M-1:0] match;

    always_comb begin
        hit       = 1'b0;
        hit_pbase = '0;
        for (int i = M - 1; i >= 0; i--) begin
            match[i] = ent[i].valid && (ent[i].vbase == lk_bvn);
            if (match[i]) begin
                hit       = 1'b1;
                hit_pbase = ent[i].pbase;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < M; i++) ent[i] <= '0;
        end else if (we && (int'(widx) < M)) begin
            ent[widx] <= '{valid: wvalid, vbase: wvbase, pbase: wpbase};
        end
    end

    // R4: a hit always has at least one matching region
    a_r4_hit_backed: assert property (@(posedge clk) disable iff (rst) hit |-> (match != '0));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int PAGE_ENTRIES  = 56,
    parameter int BLOCK_ENTRIES = 10,
    localparam int BIW = (BLOCK_ENTRIES > 1) ? $clog2(BLOCK_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_block,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             walk_rsp_valid,
    input  logic             walk_rsp_fault,
    input  logic [PPN_W-1:0] walk_rsp_ppn,
    input  logic             inv_all,
    input  logic             blk_we,
    input  logic [BIW-1:0]   blk_idx,
    input  logic             blk_valid,
    input  logic [BVN_W-1:0] blk_vbase,
    input  logic [BPN_W-1:0] blk_pbase
);
    logic pg_hit, bk_hit;
    ppn_t pg_ppn;
    bpn_t bk_pbase;
    logic pending;
    vpn_t pend_vpn;
    logic start_walk;
    logic fill_en;

    xlat_page_array #(.N(PAGE_ENTRIES)) u_pages (
        .clk(clk), .rst(rst),
        .lk_vpn(lk_vaddr[VA_W-1:PG_OFF]),
        .hit(pg_hit), .hit_ppn(pg_ppn),
        .inv_all(inv_all),
        .fill_en(fill_en), .fill_vpn(pend_vpn), .fill_ppn(walk_rsp_ppn)
    );

    xlat_block_array #(.M(BLOCK_ENTRIES)) u_blocks (
        .clk(clk), .rst(rst),
        .we(blk_we), .widx(blk_idx), .wvalid(blk_valid),
        .wvbase(blk_vbase), .wpbase(blk_pbase),
        .lk_bvn(lk_vaddr[VA_W-1:BLK_OFF]),
        .hit(bk_hit), .hit_pbase(bk_pbase)
    );

    assign start_walk = lk_valid && !pg_hit && !bk_hit && !pending && !walk_rsp_valid;
    assign fill_en    = pending && walk_rsp_valid && !walk_rsp_fault;
    assign walk_req   = pending;
    assign walk_vpn   = pend_vpn;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_block <= 1'b0;
            rsp_paddr <= '0;
            pending   <= 1'b0;
            pend_vpn  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && (pg_hit || bk_hit);
            rsp_block <= lk_valid && bk_hit;
            if (lk_valid && bk_hit)      rsp_paddr <= block_pa(bk_pbase, lk_vaddr);
            else if (lk_valid && pg_hit) rsp_paddr <= page_pa(pg_ppn, lk_vaddr);
            else                         rsp_paddr <= '0;
            if (pending && walk_rsp_valid) begin
                pending <= 1'b0;
            end else if (start_walk) begin
                pending  <= 1'b1;
                pend_vpn <= lk_vaddr[VA_W-1:PG_OFF];
            end
        end
    end

    // R1: reset leaves the outputs idle
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !rsp_valid && !walk_req);
    // R3: a region answer is always a hit
    a_r3_block_is_hit: assert property (@(posedge clk) disable iff (rst)
        rsp_block |-> (rsp_hit && rsp_valid));
    // R5: an open request holds steady until answered
    a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
        (walk_req && !walk_rsp_valid) |=> (walk_req && $stable(walk_vpn)));
    // R5: a fresh miss opens a request for its page
    a_r5_miss_opens: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !pg_hit && !bk_hit && !walk_req && !walk_rsp_valid)
        |=> (walk_req && walk_vpn == $past(lk_vaddr[VA_W-1:PG_OFF])));
    // R10: an answer closes the request with no new one
    a_r10_rsp_closes: assert property (@(posedge clk) disable iff (rst)
        (walk_req && walk_rsp_valid) |=> !walk_req);
endmodule

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
    localparam int NP = 4;
    localparam int NB = 2;
    localparam int BIW = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        rsp_valid, rsp_hit, rsp_block;
    logic [31:0] rsp_paddr;
    logic        walk_req;
    logic [19:0] walk_vpn;
    logic        walk_rsp_valid = 1'b0;
    logic        walk_rsp_fault = 1'b0;
    logic [19:0] walk_rsp_ppn = '0;
    logic        inv_all = 1'b0;
    logic        blk_we = 1'b0;
    logic [BIW-1:0] blk_idx = '0;
    logic        blk_valid = 1'b0;
    logic [12:0] blk_vbase = '0;
    logic [12:0] blk_pbase = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    xlat_cache #(.PAGE_ENTRIES(NP), .BLOCK_ENTRIES(NB)) dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_block(rsp_block),
        .rsp_paddr(rsp_paddr), .walk_req(walk_req), .walk_vpn(walk_vpn),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_fault(walk_rsp_fault),
        .walk_rsp_ppn(walk_rsp_ppn), .inv_all(inv_all), .blk_we(blk_we),
        .blk_idx(blk_idx), .blk_valid(blk_valid), .blk_vbase(blk_vbase),
        .blk_pbase(blk_pbase)
    );

    function automatic logic [19:0] vpn_of(int k);
        return 20'h40000 + 20'(k * 37);
    endfunction
    function automatic logic [19:0] ppn_of(int k);
        return 20'h80000 + 20'(k * 101);
    endfunction
    function automatic logic [31:0] va_of(int k, int off);
        return {vpn_of(k), 12'(off * 293 + 5)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic lookup(logic [31:0] va);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = va;
        @(posedge clk);
        #1;
        lk_valid = 1'b0;
    endtask

    task automatic respond(logic [19:0] ppn, logic fault);
        @(negedge clk);
        walk_rsp_valid = 1'b1;
        walk_rsp_ppn   = ppn;
        walk_rsp_fault = fault;
        @(posedge clk);
        #1;
        walk_rsp_valid = 1'b0;
        walk_rsp_fault = 1'b0;
        chk("R5 request closes", 32'(walk_req), 32'd0);
    endtask

    // page lookup expected to hit
    task automatic expect_page(string req, int k, int off);
        lookup(va_of(k, off));
        chk(req, {29'd0, rsp_valid, rsp_hit, rsp_block}, 32'd6);
        chk(req, rsp_paddr, {ppn_of(k), va_of(k, off)[11:0]});
    endtask

    // lookup expected to miss; the walk is closed with a fault
    task automatic expect_miss(string req, int k);
        lookup(va_of(k, 1));
        chk(req, {29'd0, rsp_valid, rsp_hit, rsp_block}, 32'd4);
        chk({req, " walk"}, {11'd0, walk_req, walk_vpn}, {11'd0, 1'b1, vpn_of(k)});
        respond(20'h0, 1'b1);
    endtask

    task automatic fill(int k);
        lookup(va_of(k, 0));
        chk("R5 miss before fill", {11'd0, walk_req, walk_vpn}, {11'd0, 1'b1, vpn_of(k)});
        respond(ppn_of(k), 1'b0);
    endtask

    task automatic blk_write(int idx, logic v, logic [12:0] vb, logic [12:0] pb);
        @(negedge clk);
        blk_we = 1'b1; blk_idx = BIW'(idx); blk_valid = v;
        blk_vbase = vb; blk_pbase = pb;
        @(posedge clk);
        #1;
        blk_we = 1'b0;
    endtask

    task automatic pulse_inv();
        @(negedge clk);
        inv_all = 1'b1;
        @(posedge clk);
        #1;
        inv_all = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 idle after reset", {30'd0, rsp_valid, walk_req}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1 / R5: first miss, a second miss opens nothing new
        lookup(va_of(0, 2));
        chk("R1 miss when empty", {29'd0, rsp_valid, rsp_hit, rsp_block}, 32'd4);
        chk("R5 walk opens", {11'd0, walk_req, walk_vpn}, {11'd0, 1'b1, vpn_of(0)});
        lookup(va_of(7, 2));
        chk("R5 no second request", {11'd0, walk_req, walk_vpn}, {11'd0, 1'b1, vpn_of(0)});
        respond(20'h0, 1'b1);
        expect_miss("R5 fault installs nothing", 0);

        // R2: fill all four slots, sweep offsets
        for (int k = 0; k < NP; k++) fill(k);
        for (int k = 0; k < NP; k++)
            for (int off = 0; off < 4; off++) expect_page("R2 page hit", k, off);

        // R6: evictions follow the pointer from 0
        fill(4);
        fill(5);
        expect_miss("R6 slot0 evicted", 0);
        expect_miss("R6 slot1 evicted", 1);
        for (int k = 2; k < 6; k++) expect_page("R6 survivor", k, 3);

        // R10: lookup alongside a fill sees the old contents
        lookup(va_of(6, 0));
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va_of(6, 1);
        walk_rsp_valid = 1'b1; walk_rsp_ppn = ppn_of(6);
        @(posedge clk);
        #1;
        lk_valid = 1'b0; walk_rsp_valid = 1'b0;
        chk("R10 old contents", {30'd0, rsp_valid, rsp_hit}, 32'd2);
        chk("R10 no new request", 32'(walk_req), 32'd0);
        expect_page("R10 fill landed", 6, 2);
        expect_miss("R6 slot2 evicted", 2);

        // R7: invalidate keeps regions
        blk_write(0, 1'b1, 13'h1ABC, 13'h0123);
        pulse_inv();
        for (int k = 3; k < 7; k++) expect_miss("R7 page cleared", k);
        lookup({13'h1ABC, 19'h5A5A5});
        chk("R7 region kept", {29'd0, rsp_valid, rsp_hit, rsp_block}, 32'd7);
        chk("R7 region addr", rsp_paddr, {13'h0123, 19'h5A5A5});

        // R6: refill after invalidate uses free slots, pointer stays at 3
        for (int k = 10; k < 14; k++) fill(k);
        fill(14);
        expect_miss("R6 pointer kept over invalidate", 13);
        expect_page("R6 refill", 10, 1);
        expect_page("R6 refill", 11, 1);
        expect_page("R6 refill", 12, 1);
        expect_page("R6 refill", 14, 1);

        // R3 / R4 / R8: region priority
        blk_write(1, 1'b1, vpn_of(10)[19:7], 13'h0F0F);
        lookup(va_of(10, 2));
        chk("R3 region over page", {29'd0, rsp_valid, rsp_hit, rsp_block}, 32'd7);
        chk("R3 region addr", rsp_paddr, {13'h0F0F, va_of(10, 2)[18:0]});
        blk_write(0, 1'b1, vpn_of(10)[19:7], 13'h0AAA);
        lookup(va_of(10, 3));
        chk("R4 lowest region wins", rsp_paddr, {13'h0AAA, va_of(10, 3)[18:0]});
        blk_write(0, 1'b0, vpn_of(10)[19:7], 13'h0AAA);
        lookup(va_of(10, 3));
        chk("R8 removed region", rsp_paddr, {13'h0F0F, va_of(10, 3)[18:0]});
        blk_write(1, 1'b0, 13'h0, 13'h0);
        expect_page("R8 falls to page", 10, 3);

        // R9: invalidate and fill together drop the fill
        lookup(va_of(20, 0));
        chk("R9 walk open", 32'(walk_req), 32'd1);
        @(negedge clk);
        inv_all = 1'b1; walk_rsp_valid = 1'b1; walk_rsp_ppn = ppn_of(20);
        @(posedge clk);
        #1;
        inv_all = 1'b0; walk_rsp_valid = 1'b0;
        chk("R9 walk closed", 32'(walk_req), 32'd0);
        expect_miss("R9 fill dropped", 20);
        expect_miss("R9 others cleared", 10);

        finish_run();
    end
endmodule